// File: doc/BRIEF.md
# Transmit De-emphasis Level Encoder

This block turns a serial bit stream, delivered one bit per unit-interval clock, into a signed drive-level code for a differential output stage. Each bit is weighed against the bit sent just before it. A change of polarity is sent at full swing. A bit that repeats the previous polarity is sent at a reduced swing of the same sign. The loss of a long board trace is partly undone this way, because the edges are stronger than the flat parts of the waveform.

The level is formed as a two-tap sum: the current bit on a main tap, minus the previous bit on a post tap. The post-tap weight `weight` is taken from an input and sampled with every bit, so a stress test can vary the amount of de-emphasis on the fly. The main tap is set to `FULL - weight`. A transition therefore always lands on `±FULL`, and a repeated bit lands on `±(FULL - 2*weight)`. With the default `FULL = 127` and `weight = 21`, a repeated bit gives 85/127 ≈ 0.669 of full amplitude, which is close to -3.5 dB. A bypass input sets the effective weight to zero. After reset, the first bit has no predecessor and is treated as a transition. The level code and its valid flag leave through one register stage.

Top module: `tx_deemph_encoder`

## Requirements
- R1: `level_valid` equals `bit_valid` of the previous clock cycle. The level code appears one cycle after its bit.
- R2: A valid bit whose value differs from the previous valid bit produces `+FULL` (127, 8'h7F) for a 1 and `-FULL` (-127, 8'h81) for a 0. Levels are in two's complement.
- R3: A valid bit equal to the previous valid bit produces `+(FULL-2*weight)` for a 1 and `-(FULL-2*weight)` for a 0. `weight` is the value present in the same cycle as the bit. With weight 21 this gives ±85.
- R4: The first valid bit after reset is always sent at ±FULL, whatever its value.
- R5: While `bypass` is 1, every valid bit is sent at ±FULL. The previous-bit memory still follows the bypassed bits.
- R6: Weight 0 makes repeated bits full swing. The largest weight, 63, gives ±1 on repeated bits.
- R7: A cycle with `bit_valid` low yields `level_out` = 0 and leaves the previous-bit memory unchanged. A run that is interrupted by idle cycles stays a run.
- R8: During and right after reset, `level_out` is 0 and `level_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit-interval bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Marks `bit_in` as a bit to send |
| bit_in | input | 1 | Serial data bit |
| weight | input | WEIGHT_W | Post-tap weight, sampled with each bit |
| bypass | input | 1 | Forces the effective post-tap weight to zero |
| level_out | output | LEVEL_W | Signed drive-level code |
| level_valid | output | 1 | Qualifies `level_out` |

## Verification
Bypass and the previous-bit history can meet in one cycle. This happens when `bypass` is raised on a bit that repeats the previous one. The bench raises bypass in the middle of a run of ones, and expects full swing on that bit. It then drops bypass on the next repeated one and expects the reduced level, which shows that the history kept advancing underneath. A weight change that lands on a repeated bit is judged the same way: the reduced level must use the new weight in that very cycle. The first bit after a mid-run reset is also checked. Even though it matches the pre-reset bit, it must come out at full swing.

// File: rtl/tx_deemph_encoder.sv
module tx_deemph_encoder #(
  parameter int LEVEL_W  = 8,
  parameter int WEIGHT_W = 6,
  parameter int FULL     = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_valid,
  input  logic                       bit_in,
  input  logic [WEIGHT_W-1:0]        weight,
  input  logic                       bypass,
  output logic signed [LEVEL_W-1:0]  level_out,
  output logic                       level_valid
);

  localparam logic signed [LEVEL_W-1:0] FULL_L = LEVEL_W'(FULL);

  logic                      prev_bit;
  logic                      have_prev;
  logic [WEIGHT_W-1:0]       w_eff;
  logic signed [LEVEL_W-1:0] post_mag;
  logic signed [LEVEL_W-1:0] main_mag;
  logic                      ref_bit;
  logic signed [LEVEL_W-1:0] main_tap;
  logic signed [LEVEL_W-1:0] post_tap;
  logic signed [LEVEL_W-1:0] level_next;

  // post tap sees the previous bit; with no history it sees the opposite bit
  assign w_eff      = bypass ? '0 : weight;
  assign post_mag   = $signed({{(LEVEL_W-WEIGHT_W){1'b0}}, w_eff});
  assign main_mag   = FULL_L - post_mag;
  assign ref_bit    = have_prev ? prev_bit : ~bit_in;
  assign main_tap   = bit_in  ? main_mag : -main_mag;
  assign post_tap   = ref_bit ? post_mag : -post_mag;
  assign level_next = main_tap - post_tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_out   <= '0;
      level_valid <= 1'b0;
      prev_bit    <= 1'b0;
      have_prev   <= 1'b0;
    end else begin
      level_valid <= bit_valid;
      level_out   <= bit_valid ? level_next : '0;
      if (bit_valid) begin
        prev_bit  <= bit_in;
        have_prev <= 1'b1;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> level_valid);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!level_valid && level_out == '0));

  assert_sign_tracks_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> (level_out[LEVEL_W-1] == !$past(bit_in)));

  assert_bypass_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bypass) |=> (level_out == FULL_L || level_out == -FULL_L));

  assert_first_bit_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !have_prev) |=> (level_out == FULL_L || level_out == -FULL_L));

endmodule

// File: tb/tx_deemph_encoder_tb.sv
module tx_deemph_encoder_tb;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bit_valid;
  logic              bit_in;
  logic [5:0]        weight;
  logic              bypass;
  logic signed [7:0] level_out;
  logic              level_valid;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  tx_deemph_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .weight(weight), .bypass(bypass), .level_out(level_out), .level_valid(level_valid)
  );

  // {bit_valid, bit_in, bypass, weight, exp_valid, exp_level}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 6'd21, 1'b1, 8'h7F},  // R4 first bit full
    {1'b1, 1'b1, 1'b0, 6'd21, 1'b1, 8'h55},  // R3 repeat +85
    {1'b1, 1'b1, 1'b0, 6'd21, 1'b1, 8'h55},  // R3
    {1'b1, 1'b0, 1'b0, 6'd21, 1'b1, 8'h81},  // R2 transition -127
    {1'b1, 1'b0, 1'b0, 6'd21, 1'b1, 8'hAB},  // R3 repeat -85
    {1'b0, 1'b1, 1'b0, 6'd21, 1'b0, 8'h00},  // R7 idle
    {1'b1, 1'b0, 1'b0, 6'd21, 1'b1, 8'hAB},  // R7 run survives idle
    {1'b1, 1'b1, 1'b1, 6'd21, 1'b1, 8'h7F},  // R5 bypass transition
    {1'b1, 1'b1, 1'b1, 6'd21, 1'b1, 8'h7F},  // R5 bypass repeat full
    {1'b1, 1'b1, 1'b0, 6'd21, 1'b1, 8'h55},  // R5 history kept
    {1'b1, 1'b1, 1'b0, 6'd0,  1'b1, 8'h7F},  // R6 weight 0
    {1'b1, 1'b1, 1'b0, 6'd63, 1'b1, 8'h01},  // R6 weight 63 -> +1
    {1'b1, 1'b0, 1'b0, 6'd63, 1'b1, 8'h81},  // R2
    {1'b1, 1'b0, 1'b0, 6'd63, 1'b1, 8'hFF},  // R6 -> -1
    {1'b1, 1'b1, 1'b0, 6'd10, 1'b1, 8'h7F},  // R2
    {1'b1, 1'b1, 1'b0, 6'd10, 1'b1, 8'h6B},  // R3 weight 10 -> 107
    {1'b1, 1'b0, 1'b0, 6'd10, 1'b1, 8'h81}   // R2
  };

  task automatic check(input string req, input logic got_v, input logic [7:0] got_l,
                       input logic exp_v, input logic [7:0] exp_l);
    total++;
    if (got_v !== exp_v || got_l !== exp_l) begin
      bad++;
      $display("FAIL %s: got valid=%0b level=%h, expected valid=%0b level=%h",
               req, got_v, got_l, exp_v, exp_l);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic byp, input logic [5:0] w);
    bit_valid = v; bit_in = b; bypass = byp; weight = w;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; bypass = 1'b0; weight = 6'd21;
    @(negedge clk); @(negedge clk);
    check("R8 in reset", level_valid, level_out, 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", level_valid, level_out, 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:9]);
      check($sformatf("R1 vector %0d", i), level_valid, level_out, VEC[i][8], VEC[i][7:0]);
    end

    // R4: reset in a run of zeros; the next zero is still full swing
    drive(1'b1, 1'b0, 1'b0, 6'd21);
    check("R2 before reset", level_valid, level_out, 1'b1, 8'hAB);
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 6'd21);
    check("R8 mid-run reset", level_valid, level_out, 1'b0, 8'h00);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 6'd21);
    check("R4 first bit after reset", level_valid, level_out, 1'b1, 8'h81);
    drive(1'b1, 1'b0, 1'b0, 6'd21);
    check("R3 repeat after reset", level_valid, level_out, 1'b1, 8'hAB);

    // R7: several idle cycles with bit_in toggling do not disturb history
    drive(1'b0, 1'b1, 1'b0, 6'd21);
    drive(1'b0, 1'b1, 1'b0, 6'd21);
    check("R7 idle level", level_valid, level_out, 1'b0, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 6'd21);
    check("R7 history kept over idle", level_valid, level_out, 1'b1, 8'hAB);

    bit_valid = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule